// File: doc/BRIEF.md
# DS3 Nibble-Parallel Payload Input Interface

This block is the transmit-side terminal port of a DS3 framer running in nibble-parallel mode. It runs on the high-speed line clock and divides it by four to produce a nibble clock for the terminal equipment. The terminal launches one 4-bit payload nibble per nibble-clock period. The block samples each nibble and tags it with its position inside the 1176-nibble DS3 payload frame. A downstream overhead inserter can then place the payload bits.

Two timing options are supported. In frame-slave operation, the terminal marks the first nibble of each frame with a one-nibble frame reference pulse. The block snaps its nibble counter to that pulse and flags any pulse that disagrees with its own count. In frame-master operation, the counter free-runs, the reference input is ignored, and the block reports frame starts itself.

The output is a valid-only stream: a one-cycle `pay_valid` strobe with the nibble and its index. There is no ready input and no back-pressure. Payload arrives at the fixed line rate, so the consumer must take every beat in the cycle it is offered. Nibble, index and frame-start stay stable until the next beat.

Top module: `ds3n_nib_tx_if`

## Requirements
- R1: While `rst_sync` is high at a line-clock edge, the divider phase and nibble counter clear. One edge later, `nib_clk_out`, `pay_valid`, `frame_start`, `align_err`, `pay_nibble` and `pay_index` are all 0.
- R2: `nib_clk_out` is the line clock divided by exactly 4, high for 2 of every 4 line-clock cycles. Its first rise follows the 2nd line-clock edge after reset (or enable) is released.
- R3: The data and frame reference are sampled at the line-clock edge where `nib_clk_out` falls, which is the 4th edge of each nibble period. `pay_valid` is high for exactly one line-clock cycle after that edge. `pay_nibble` then carries the sampled data, and it holds until the next capture.
- R4: `pay_index` runs 0 through 1175, increments by one per captured nibble, and wraps from 1175 to 0. The first nibble after reset has index 0.
- R5: `frame_start` is 1 from the capture of an index-0 nibble until the next capture, and 0 otherwise, in both timing options.
- R6: `tref_sel` = 2'b01 selects frame-slave operation; every other value selects frame-master operation. In frame-master operation `frame_ref_in` has no effect on `pay_index` or `align_err`.
- R7: In frame-slave operation, a reference sampled high when the expected index is 0 gives index 0 and leaves `align_err` low.
- R8: In frame-slave operation, a reference sampled high at any other expected index does three things. The nibble gets index 0. `align_err` is high for the single cycle of that `pay_valid`. Counting continues at 1.
- R9: While `nib_mode_en` is low, the block is held as in reset: `nib_clk_out` is low and no `pay_valid` is produced. Raising it restarts timing exactly as a reset release does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_line | input | 1 | Line clock, the transmit timing reference |
| rst_sync | input | 1 | Synchronous reset, active high |
| nib_mode_en | input | 1 | Static enable for nibble-parallel operation |
| tref_sel | input | 2 | Timing option: 01 frame-slave, others frame-master |
| frame_ref_in | input | 1 | Frame reference from terminal, high for the first nibble of a frame |
| nib_data_in | input | NIB_W (4) | Payload nibble from terminal |
| nib_clk_out | output | 1 | Nibble clock, line clock divided by 4 |
| pay_valid | output | 1 | One-cycle strobe per captured nibble |
| pay_nibble | output | NIB_W (4) | Captured payload nibble |
| pay_index | output | IDX_W (11) | Position of the nibble in the frame |
| frame_start | output | 1 | High while the current beat is nibble 0 |
| align_err | output | 1 | One-cycle flag for a reference pulse off the frame boundary |

## Verification
The assertions assume `tref_sel` changes only while `nib_mode_en` is low or reset is active. They also assume the downstream consumer takes every `pay_valid` beat, since no stall exists.

The stimulus changes data and the frame reference only on falling line-clock edges directly after a capture. It holds them for the whole 4-cycle nibble period, so each value is stable around its sampling edge. Timing-option and enable changes are made only at those same nibble boundaries, with the mode input low, or under reset.

// File: rtl/ds3n_pkg.sv
package ds3n_pkg;

  // timing option chosen by the 2-bit select field
  typedef enum logic {
    TMODE_MASTER = 1'b0,
    TMODE_SLAVE  = 1'b1
  } tmode_e;

  localparam logic [1:0] SEL_SLAVE = 2'b01;

  function automatic tmode_e decode_sel(input logic [1:0] sel);
    return (sel == SEL_SLAVE) ? TMODE_SLAVE : TMODE_MASTER;
  endfunction

endpackage

// File: rtl/ds3n_clkdiv.sv
// Phase counter producing the nibble clock and the capture enable.
module ds3n_clkdiv #(
  parameter int DIV_RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic nib_clk,
  output logic sample_now
);
  localparam int PH_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV_RATIO / 2);
  localparam bit   IS_POW2 = ((DIV_RATIO & (DIV_RATIO - 1)) == 0);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  generate
    if (IS_POW2) begin : g_pow2
      // top phase bit is already a 50% duty divided clock
      assign nib_clk = phase[PH_W-1];
    end else begin : g_cmp
      assign nib_clk = (phase >= PH_HALF);
    end
  endgenerate

  // last line-clock edge of the nibble period
  assign sample_now = run && (phase == PH_LAST);

endmodule

// File: rtl/ds3n_pos_track.sv
// Nibble position counter with optional realignment to a frame reference.
module ds3n_pos_track #(
  parameter int FRAME_NIBS = 1176,
  parameter int IDX_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sample_now,
  input  ds3n_pkg::tmode_e tmode,
  input  logic             ref_in,
  output logic [IDX_W-1:0] idx_use,
  output logic             misalign,
  output logic             sof
);
  import ds3n_pkg::*;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_NIBS - 1);

  logic [IDX_W-1:0] expect_idx;
  logic             realign;

  always_comb begin
    realign  = (tmode == TMODE_SLAVE) && ref_in;
    idx_use  = realign ? '0 : expect_idx;
    misalign = realign && (expect_idx != '0);
    sof      = (idx_use == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      expect_idx <= '0;
    end else if (sample_now) begin
      expect_idx <= (idx_use == IDX_LAST) ? '0 : idx_use + 1'b1;
    end
  end

endmodule

// File: rtl/ds3n_capture.sv
// Output register stage: one-cycle valid, held payload fields.
module ds3n_capture #(
  parameter int NIB_W = 4,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sample_now,
  input  logic [NIB_W-1:0] nib_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             misalign_in,
  input  logic             sof_in,
  output logic             valid_q,
  output logic [NIB_W-1:0] nib_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             sof_q,
  output logic             err_q
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      sof_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= sample_now;
      err_q   <= sample_now && misalign_in;
      if (sample_now) begin
        idx_q <= idx_in;
        sof_q <= sof_in;
      end
    end
  end

  generate
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          nib_q[b] <= 1'b0;
        end else if (sample_now) begin
          nib_q[b] <= nib_in[b];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ds3n_nib_tx_if.sv
module ds3n_nib_tx_if #(
  parameter int NIB_W      = 4,
  parameter int FRAME_NIBS = 1176,
  parameter int DIV_RATIO  = 4,
  parameter int IDX_W      = $clog2(FRAME_NIBS)
) (
  input  logic             clk_line,
  input  logic             rst_sync,
  input  logic             nib_mode_en,
  input  logic [1:0]       tref_sel,
  input  logic             frame_ref_in,
  input  logic [NIB_W-1:0] nib_data_in,
  output logic             nib_clk_out,
  output logic             pay_valid,
  output logic [NIB_W-1:0] pay_nibble,
  output logic [IDX_W-1:0] pay_index,
  output logic             frame_start,
  output logic             align_err
);
  import ds3n_pkg::*;

  tmode_e           tmode;
  logic             smp;
  logic [IDX_W-1:0] idx_use;
  logic             mis;
  logic             sof;

  assign tmode = decode_sel(tref_sel);

  ds3n_clkdiv #(
    .DIV_RATIO(DIV_RATIO)
  ) u_div (
    .clk        (clk_line),
    .rst        (rst_sync),
    .run        (nib_mode_en),
    .nib_clk    (nib_clk_out),
    .sample_now (smp)
  );

  ds3n_pos_track #(
    .FRAME_NIBS(FRAME_NIBS),
    .IDX_W     (IDX_W)
  ) u_pos (
    .clk        (clk_line),
    .rst        (rst_sync),
    .run        (nib_mode_en),
    .sample_now (smp),
    .tmode      (tmode),
    .ref_in     (frame_ref_in),
    .idx_use    (idx_use),
    .misalign   (mis),
    .sof        (sof)
  );

  ds3n_capture #(
    .NIB_W(NIB_W),
    .IDX_W(IDX_W)
  ) u_cap (
    .clk         (clk_line),
    .rst         (rst_sync),
    .run         (nib_mode_en),
    .sample_now  (smp),
    .nib_in      (nib_data_in),
    .idx_in      (idx_use),
    .misalign_in (mis),
    .sof_in      (sof),
    .valid_q     (pay_valid),
    .nib_q       (pay_nibble),
    .idx_q       (pay_index),
    .sof_q       (frame_start),
    .err_q       (align_err)
  );

endmodule

// File: rtl/ds3n_nib_tx_chk.sv
module ds3n_nib_tx_chk #(
  parameter int FRAME_NIBS = 1176,
  parameter int IDX_W      = 11
) (
  input logic             clk_line,
  input logic             rst_sync,
  input logic             nib_mode_en,
  input logic [1:0]       tref_sel,
  input logic             nib_clk_out,
  input logic             pay_valid,
  input logic [IDX_W-1:0] pay_index,
  input logic             frame_start,
  input logic             align_err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_NIBS - 1);

  logic [IDX_W-1:0] prev_idx;
  logic             have_prev;

  always_ff @(posedge clk_line) begin
    if (rst_sync || !nib_mode_en) begin
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else if (pay_valid) begin
      have_prev <= 1'b1;
      prev_idx  <= pay_index;
    end
  end

  assert_nibclk_shape_R2: assert property (@(posedge clk_line)
    disable iff (rst_sync || !nib_mode_en)
    $rose(nib_clk_out) |=> nib_clk_out ##1 !nib_clk_out);

  assert_capture_at_fall_R3: assert property (@(posedge clk_line)
    disable iff (rst_sync || !nib_mode_en)
    pay_valid |-> $fell(nib_clk_out));

  assert_index_range_R4: assert property (@(posedge clk_line)
    disable iff (rst_sync)
    pay_valid |-> (pay_index <= LAST));

  assert_index_step_R4: assert property (@(posedge clk_line)
    disable iff (rst_sync || !nib_mode_en)
    (pay_valid && have_prev && !align_err) |->
      (pay_index == ((prev_idx == LAST) ? '0 : prev_idx + 1'b1)));

  assert_start_marks_zero_R5: assert property (@(posedge clk_line)
    disable iff (rst_sync)
    pay_valid |-> (frame_start == (pay_index == '0)));

  assert_err_only_slave_R8: assert property (@(posedge clk_line)
    disable iff (rst_sync)
    align_err |-> (pay_valid && pay_index == '0 && tref_sel == 2'b01));

  assert_hold_when_off_R9: assert property (@(posedge clk_line)
    disable iff (rst_sync)
    !nib_mode_en |=> (!pay_valid && !nib_clk_out));

endmodule

bind ds3n_nib_tx_if ds3n_nib_tx_chk #(
  .FRAME_NIBS(FRAME_NIBS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_line    (clk_line),
  .rst_sync    (rst_sync),
  .nib_mode_en (nib_mode_en),
  .tref_sel    (tref_sel),
  .nib_clk_out (nib_clk_out),
  .pay_valid   (pay_valid),
  .pay_index   (pay_index),
  .frame_start (frame_start),
  .align_err   (align_err)
);

// File: tb/sim_ds3n_nib_tx_if.sv
`timescale 1ns/1ps
module sim_ds3n_nib_tx_if;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_IDX   = 1175;

  logic        clk_line = 1'b0;
  logic        rst_sync = 1'b1;
  logic        nib_mode_en = 1'b1;
  logic [1:0]  tref_sel = 2'b00;
  logic        frame_ref_in = 1'b0;
  logic [3:0]  nib_data_in = 4'h0;
  logic        nib_clk_out;
  logic        pay_valid;
  logic [3:0]  pay_nibble;
  logic [10:0] pay_index;
  logic        frame_start;
  logic        align_err;

  int n_checks = 0;
  int n_errors = 0;
  int tb_idx   = 0;
  bit tb_start = 1'b0;

  always #(CLK_PERIOD/2) clk_line = ~clk_line;

  ds3n_nib_tx_if u0 (
    .clk_line     (clk_line),
    .rst_sync     (rst_sync),
    .nib_mode_en  (nib_mode_en),
    .tref_sel     (tref_sel),
    .frame_ref_in (frame_ref_in),
    .nib_data_in  (nib_data_in),
    .nib_clk_out  (nib_clk_out),
    .pay_valid    (pay_valid),
    .pay_nibble   (pay_nibble),
    .pay_index    (pay_index),
    .frame_start  (frame_start),
    .align_err    (align_err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // One nibble period, started on the falling edge right after a capture.
  task automatic nib(input logic [3:0] d, input logic r, input bit slave,
                     input string rq);
    int  e_idx;
    bit  e_err;
    if (slave && r) begin
      e_idx = 0;
      e_err = (tb_idx != 0);
    end else begin
      e_idx = tb_idx;
      e_err = 1'b0;
    end
    nib_data_in  = d;
    frame_ref_in = r;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk_line);
      chk(pay_valid == 1'b0, "R3", "valid between captures", int'(pay_valid), 0);
      chk(align_err == 1'b0, "R8", "err between captures", int'(align_err), 0);
      chk(frame_start == tb_start, "R5", "start held", int'(frame_start), int'(tb_start));
      chk(nib_clk_out == (k >= 2), "R2", "nib clock phase", int'(nib_clk_out), int'(k >= 2));
    end
    @(negedge clk_line);
    chk(pay_valid == 1'b1, "R3", "valid at capture", int'(pay_valid), 1);
    chk(nib_clk_out == 1'b0, "R2", "nib clock low after fall", int'(nib_clk_out), 0);
    chk(pay_nibble == d, "R3", "nibble", int'(pay_nibble), int'(d));
    chk(pay_index == 11'(e_idx), rq, "index", int'(pay_index), e_idx);
    chk(frame_start == (e_idx == 0), "R5", "frame start", int'(frame_start), int'(e_idx == 0));
    chk(align_err == e_err, rq, "align err", int'(align_err), int'(e_err));
    tb_start = (e_idx == 0);
    tb_idx   = (e_idx == LAST_IDX) ? 0 : e_idx + 1;
  endtask

  task automatic do_reset();
    @(negedge clk_line);
    rst_sync = 1'b1;
    frame_ref_in = 1'b0;
    repeat (2) @(negedge clk_line);
    chk(nib_clk_out == 1'b0, "R1", "nib clock in reset", int'(nib_clk_out), 0);
    chk(pay_valid == 1'b0, "R1", "valid in reset", int'(pay_valid), 0);
    chk(frame_start == 1'b0, "R1", "start in reset", int'(frame_start), 0);
    chk(align_err == 1'b0, "R1", "err in reset", int'(align_err), 0);
    chk(pay_index == 11'd0, "R1", "index in reset", int'(pay_index), 0);
    chk(pay_nibble == 4'd0, "R1", "nibble in reset", int'(pay_nibble), 0);
    rst_sync = 1'b0;
    tb_idx   = 0;
    tb_start = 1'b0;
  endtask

  task automatic t_master_frame();
    tref_sel = 2'b00;
    do_reset();
    for (int i = 0; i < 1180; i++) nib(4'(i ^ 5), 1'b0, 1'b0, "R4");
  endtask

  task automatic t_master_ignores_ref();
    tref_sel = 2'b10;
    do_reset();
    for (int i = 0; i < 20; i++) nib(4'(3 * i), (i % 6) == 5, 1'b0, "R6");
  endtask

  task automatic t_slave_at_wrap();
    tref_sel = 2'b01;
    do_reset();
    nib(4'hA, 1'b1, 1'b1, "R7");
    for (int i = 1; i < 1176; i++) nib(4'(i), 1'b0, 1'b1, "R4");
    nib(4'hC, 1'b1, 1'b1, "R7");
    for (int i = 0; i < 4; i++) nib(4'(9 + i), 1'b0, 1'b1, "R7");
  endtask

  task automatic t_slave_realign();
    tref_sel = 2'b01;
    do_reset();
    for (int i = 0; i < 7; i++) nib(4'(i), 1'b0, 1'b1, "R4");
    nib(4'hF, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 12; i++) nib(4'(i + 2), 1'b0, 1'b1, "R8");
    nib(4'h1, 1'b1, 1'b1, "R8");
    nib(4'h2, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 3; i++) nib(4'(i), 1'b0, 1'b1, "R8");
  endtask

  task automatic t_disable();
    tref_sel = 2'b11;
    do_reset();
    for (int i = 0; i < 5; i++) nib(4'(i + 4), 1'b0, 1'b0, "R4");
    nib_mode_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_line);
      chk(pay_valid == 1'b0, "R9", "valid while off", int'(pay_valid), 0);
      chk(nib_clk_out == 1'b0, "R9", "nib clock while off", int'(nib_clk_out), 0);
    end
    chk(pay_index == 11'd0, "R9", "index while off", int'(pay_index), 0);
    nib_mode_en = 1'b1;
    tb_idx   = 0;
    tb_start = 1'b0;
    for (int i = 0; i < 6; i++) nib(4'(15 - i), 1'b0, 1'b0, "R9");
  endtask

  initial begin
    t_master_frame();
    t_master_ignores_ref();
    t_slave_at_wrap();
    t_slave_realign();
    t_disable();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule